// File: doc/BRIEF.md
# MII/RMII Datapath Width Converter

This block translates between a 4-bit nibble stream and a 2-bit reduced-pin stream. Both directions run on one 50 MHz reference clock. In the transmit direction, dibits qualified by a transmit enable are packed into nibbles. Each finished nibble is announced by a one-cycle valid strobe. In the receive direction, nibbles offered with a data-valid flag are split into dibits and driven out with a combined carrier-sense/data-valid signal.

A speed input selects the rate. At 100 Mb/s one dibit moves on every reference clock. At 10 Mb/s each dibit occupies a window of ten reference clocks: transmit samples once per window, and receive holds each dibit for the whole window. Receive nibbles are pulled from the source with a take strobe, so the source controls frame length simply by holding its valid flag.

Top module: `mii_rmii_bridge`

## Requirements
- R1: After reset, `rmii_crs_dv_o` is 0, `rmii_rxd_o` is 0 and `mii_tx_vld_o` is 0.
- R2: At 100 Mb/s (`speed_100_i`=1), a dibit is captured on every clock with `rmii_tx_en_i` high. The first dibit of each pair forms nibble bits [1:0] and the second forms bits [3:2]. `mii_tx_vld_o` is high for the one cycle after the second dibit is captured, with the nibble on `mii_txd_o`.
- R3: While `rmii_tx_en_i` is low, `rmii_txd_i` has no effect and `mii_tx_vld_o` stays low on the following cycle.
- R4: When the transmit enable drops after an odd number of dibits, the half-built nibble is dropped. The next frame's first dibit again lands in bits [1:0].
- R5: At 10 Mb/s (`speed_100_i`=0), transmit samples only the first clock of each ten-clock window, counted from the rise of the transmit enable. Values on the other nine clocks are ignored.
- R6: `mii_rx_take_o` pulses in the cycle a nibble is accepted. `rmii_crs_dv_o` is high from the next cycle on, and the low dibit (bits [1:0]) is sent before the high dibit (bits [3:2]).
- R7: While `mii_rx_dv_i` stays high, nibbles follow each other with no gap. `rmii_crs_dv_o` stays high for exactly two dibit periods per nibble.
- R8: `rmii_crs_dv_o` falls right after the last dibit period, and only when `mii_rx_dv_i` was low in that last cycle. While it is low, `rmii_rxd_o` is 0.
- R9: At 10 Mb/s, each receive dibit is held on `rmii_rxd_o` for ten consecutive clocks.
- R10: `mii_rx_take_o` is never high while `mii_rx_dv_i` is low, and `rmii_crs_dv_o` never rises without a nibble being taken.
- R11: `mii_tx_vld_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| speed_100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| rmii_tx_en_i | input | 1 | Transmit dibit enable |
| rmii_txd_i | input | 2 | Transmit dibit |
| mii_txd_o | output | 4 | Assembled transmit nibble |
| mii_tx_vld_o | output | 1 | One-cycle strobe for a new nibble |
| mii_rxd_i | input | 4 | Receive nibble from the source |
| mii_rx_dv_i | input | 1 | Receive nibble valid |
| mii_rx_take_o | output | 1 | Nibble accepted this cycle |
| rmii_crs_dv_o | output | 1 | Combined carrier sense / data valid |
| rmii_rxd_o | output | 2 | Receive dibit |

## Verification
On every cycle, the assertions check the following:
- the transmit strobe is never high on consecutive cycles and never follows an idle enable;
- a take is always followed by asserted carrier/valid;
- carrier/valid falls only after a cycle without source data;
- at 10 Mb/s, every received dibit run is a multiple of ten clocks.

Only the bench scenarios can show that the data is correct. These cover dibit ordering within a nibble, the loss of an odd trailing dibit, the rejection of values off the sample clock at 10 Mb/s, and gapless back-to-back receive nibbles whose total carrier length matches the frame.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned DIB_W  = 2;
  localparam int unsigned REP_10 = 10;

  typedef enum logic {
    RATE_10M  = 1'b0,
    RATE_100M = 1'b1
  } rate_e;
endpackage

// File: rtl/mrb_beat_cnt.sv
module mrb_beat_cnt #(
  parameter int unsigned REP = mrb_pkg::REP_10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic speed_100_i,
  input  logic run_i,
  output logic first_o,
  output logic last_o
);
  localparam int unsigned CW = (REP > 1) ? $clog2(REP) : 1;

  logic [CW-1:0] cnt_q;

  assign first_o = (cnt_q == '0);
  assign last_o  = (mrb_pkg::rate_e'(speed_100_i) == mrb_pkg::RATE_100M) ||
                   (cnt_q == CW'(REP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || last_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mrb_tx_pack.sv
module mrb_tx_pack #(
  parameter int unsigned NIB_W = mrb_pkg::NIB_W,
  parameter int unsigned DIB_W = mrb_pkg::DIB_W,
  parameter int unsigned REP   = mrb_pkg::REP_10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             speed_100_i,
  input  logic             tx_en_i,
  input  logic [DIB_W-1:0] txd_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             nib_vld_o
);
  localparam int unsigned DPN = NIB_W / DIB_W;
  localparam int unsigned IW  = (DPN > 1) ? $clog2(DPN) : 1;

  logic             first;
  logic             last_unused;
  logic             sample;
  logic [IW-1:0]    idx_q;
  logic [NIB_W-1:0] sh_q;
  logic [NIB_W-1:0] nib_next;

  mrb_beat_cnt #(.REP(REP)) u_beat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_100_i (speed_100_i),
    .run_i       (tx_en_i),
    .first_o     (first),
    .last_o      (last_unused)
  );

  // one sample per window: first clock after enable rise, then every REP
  assign sample = tx_en_i && first;

  always_comb begin
    nib_next = sh_q;
    nib_next[idx_q*DIB_W +: DIB_W] = txd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      sh_q      <= '0;
      nib_o     <= '0;
      nib_vld_o <= 1'b0;
    end else begin
      nib_vld_o <= 1'b0;
      if (!tx_en_i) begin
        idx_q <= '0;
      end else if (sample) begin
        if (idx_q == IW'(DPN - 1)) begin
          nib_o     <= nib_next;
          nib_vld_o <= 1'b1;
          idx_q     <= '0;
        end else begin
          sh_q  <= nib_next;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mrb_rx_serial.sv
module mrb_rx_serial #(
  parameter int unsigned NIB_W = mrb_pkg::NIB_W,
  parameter int unsigned DIB_W = mrb_pkg::DIB_W,
  parameter int unsigned REP   = mrb_pkg::REP_10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             speed_100_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             nib_dv_i,
  output logic             take_o,
  output logic             crs_dv_o,
  output logic [DIB_W-1:0] rxd_o
);
  localparam int unsigned DPN = NIB_W / DIB_W;
  localparam int unsigned IW  = (DPN > 1) ? $clog2(DPN) : 1;

  logic             crs_q;
  logic [IW-1:0]    idx_q;
  logic [NIB_W-1:0] sh_q;
  logic             first_unused;
  logic             beat_end;
  logic             last_dib;

  mrb_beat_cnt #(.REP(REP)) u_beat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_100_i (speed_100_i),
    .run_i       (crs_q),
    .first_o     (first_unused),
    .last_o      (beat_end)
  );

  assign last_dib = (idx_q == IW'(DPN - 1));
  // accept when idle, or in the final clock of the final dibit
  assign take_o   = nib_dv_i && (!crs_q || (last_dib && beat_end));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crs_q <= 1'b0;
      idx_q <= '0;
      sh_q  <= '0;
    end else if (take_o) begin
      sh_q  <= nib_i;
      idx_q <= '0;
      crs_q <= 1'b1;
    end else if (crs_q && beat_end) begin
      if (last_dib) crs_q <= 1'b0;
      else          idx_q <= idx_q + 1'b1;
    end
  end

  assign crs_dv_o = crs_q;
  assign rxd_o    = crs_q ? sh_q[idx_q*DIB_W +: DIB_W] : '0;
endmodule

// File: rtl/mii_rmii_bridge.sv
module mii_rmii_bridge #(
  parameter int unsigned NIB_W = mrb_pkg::NIB_W,
  parameter int unsigned DIB_W = mrb_pkg::DIB_W,
  parameter int unsigned REP   = mrb_pkg::REP_10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             speed_100_i,
  input  logic             rmii_tx_en_i,
  input  logic [DIB_W-1:0] rmii_txd_i,
  output logic [NIB_W-1:0] mii_txd_o,
  output logic             mii_tx_vld_o,
  input  logic [NIB_W-1:0] mii_rxd_i,
  input  logic             mii_rx_dv_i,
  output logic             mii_rx_take_o,
  output logic             rmii_crs_dv_o,
  output logic [DIB_W-1:0] rmii_rxd_o
);
  mrb_tx_pack #(.NIB_W(NIB_W), .DIB_W(DIB_W), .REP(REP)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_100_i (speed_100_i),
    .tx_en_i     (rmii_tx_en_i),
    .txd_i       (rmii_txd_i),
    .nib_o       (mii_txd_o),
    .nib_vld_o   (mii_tx_vld_o)
  );

  mrb_rx_serial #(.NIB_W(NIB_W), .DIB_W(DIB_W), .REP(REP)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_100_i (speed_100_i),
    .nib_i       (mii_rxd_i),
    .nib_dv_i    (mii_rx_dv_i),
    .take_o      (mii_rx_take_o),
    .crs_dv_o    (rmii_crs_dv_o),
    .rxd_o       (rmii_rxd_o)
  );
endmodule

// File: rtl/mrb_checker.sv
module mrb_checker #(
  parameter int unsigned NIB_W = mrb_pkg::NIB_W,
  parameter int unsigned DIB_W = mrb_pkg::DIB_W,
  parameter int unsigned REP   = mrb_pkg::REP_10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             speed_100_i,
  input logic             rmii_tx_en_i,
  input logic             mii_tx_vld_o,
  input logic             mii_rx_dv_i,
  input logic             mii_rx_take_o,
  input logic             rmii_crs_dv_o,
  input logic [DIB_W-1:0] rmii_rxd_o
);
  logic [DIB_W-1:0] prev_rxd_q;
  logic             prev_crs_q;
  logic             prev_spd_q;
  logic [15:0]      run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_rxd_q <= '0;
      prev_crs_q <= 1'b0;
      prev_spd_q <= 1'b1;
      run_q      <= '0;
    end else begin
      prev_rxd_q <= rmii_rxd_o;
      prev_crs_q <= rmii_crs_dv_o;
      prev_spd_q <= speed_100_i;
      if (rmii_crs_dv_o && prev_crs_q && rmii_rxd_o == prev_rxd_q)
        run_q <= run_q + 1'b1;
      else
        run_q <= 16'd1;
    end
  end

  assert_vld_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mii_tx_vld_o |=> !mii_tx_vld_o);

  assert_idle_no_vld_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rmii_tx_en_i |=> !mii_tx_vld_o);

  assert_take_needs_dv_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mii_rx_take_o |-> mii_rx_dv_i);

  assert_take_sets_crs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mii_rx_take_o |=> rmii_crs_dv_o);

  assert_crs_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rmii_crs_dv_o) |-> $past(mii_rx_take_o));

  assert_crs_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rmii_crs_dv_o) |-> !$past(mii_rx_dv_i));

  assert_slow_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rmii_crs_dv_o && prev_crs_q && rmii_rxd_o != prev_rxd_q &&
     !speed_100_i && !prev_spd_q) |-> (run_q % REP == 0));
endmodule

bind mii_rmii_bridge mrb_checker #(.NIB_W(NIB_W), .DIB_W(DIB_W), .REP(REP)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .speed_100_i   (speed_100_i),
  .rmii_tx_en_i  (rmii_tx_en_i),
  .mii_tx_vld_o  (mii_tx_vld_o),
  .mii_rx_dv_i   (mii_rx_dv_i),
  .mii_rx_take_o (mii_rx_take_o),
  .rmii_crs_dv_o (rmii_crs_dv_o),
  .rmii_rxd_o    (rmii_rxd_o)
);

// File: tb/mii_rmii_bridge_tb.sv
module mii_rmii_bridge_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed = 1'b1;
  logic       tx_en = 1'b0;
  logic [1:0] txd = '0;
  logic [3:0] tx_nib;
  logic       tx_vld;
  logic [3:0] rx_nib = '0;
  logic       rx_dv = 1'b0;
  logic       rx_take;
  logic       crs_dv;
  logic [1:0] rxd;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mii_rmii_bridge u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .speed_100_i   (speed),
    .rmii_tx_en_i  (tx_en),
    .rmii_txd_i    (txd),
    .mii_txd_o     (tx_nib),
    .mii_tx_vld_o  (tx_vld),
    .mii_rxd_i     (rx_nib),
    .mii_rx_dv_i   (rx_dv),
    .mii_rx_take_o (rx_take),
    .rmii_crs_dv_o (crs_dv),
    .rmii_rxd_o    (rxd)
  );

  // monitors
  logic [3:0] tx_got [64];
  int         tx_cnt = 0;
  logic [1:0] rx_got [256];
  int         rx_cnt = 0;
  int         rx_first = -1;
  int         rx_last = -1;
  int         rx_bad = 0;
  int         take_cnt = 0;
  int         cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (tx_vld) begin
      if (tx_cnt < 64) tx_got[tx_cnt] = tx_nib;
      tx_cnt++;
    end
    if (crs_dv) begin
      if (rx_cnt < 256) rx_got[rx_cnt] = rxd;
      if (rx_first < 0) rx_first = cyc;
      rx_last = cyc;
      rx_cnt++;
    end else if (rxd != 2'b00) begin
      rx_bad++;
    end
  end

  always @(posedge clk) if (rst_n && rx_take) take_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [1:0] dib [64];
  logic [3:0] src [16];

  task automatic clear_mon();
    tx_cnt = 0; rx_cnt = 0; rx_first = -1; rx_last = -1; rx_bad = 0; take_cnt = 0;
  endtask

  // send n dibits; at 10M, nine off-sample clocks carry inverted data
  task automatic tx_drive(input int n, input bit fast);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tx_en = 1'b1; txd = dib[i];
      if (!fast) for (int k = 0; k < 9; k++) begin
        @(negedge clk); txd = ~dib[i];
      end
    end
    @(negedge clk); tx_en = 1'b0; txd = 2'b00;
  endtask

  task automatic t_reset();
    chk(crs_dv == 1'b0, "R1 crs_dv", crs_dv, 0);
    chk(rxd == 2'b00, "R1 rxd", rxd, 0);
    chk(tx_vld == 1'b0, "R1 tx_vld", tx_vld, 0);
  endtask

  task automatic t_tx_idle();
    clear_mon();
    speed = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); tx_en = 1'b0; txd = 2'(i);
    end
    repeat (3) @(negedge clk);
    chk(tx_cnt == 0, "R3 idle nibbles", tx_cnt, 0);
  endtask

  task automatic t_tx_frame(input bit fast, input int seed, input string req);
    int nn;
    clear_mon();
    speed = fast;
    for (int i = 0; i < 16; i++) dib[i] = 2'((i * 3 + seed + i / 4) % 4);
    tx_drive(16, fast);
    repeat (12) @(negedge clk);
    chk(tx_cnt == 8, {req, " nibble count"}, tx_cnt, 8);
    nn = (tx_cnt < 8) ? tx_cnt : 8;
    for (int k = 0; k < nn; k++)
      chk(tx_got[k] == {dib[2*k+1], dib[2*k]}, {req, " nibble data"},
          tx_got[k], {dib[2*k+1], dib[2*k]});
  endtask

  task automatic t_tx_odd();
    logic [3:0] e0, e1;
    clear_mon();
    speed = 1'b1;
    dib[0] = 2'd1; dib[1] = 2'd2; dib[2] = 2'd3;
    e0 = {dib[1], dib[0]};
    tx_drive(3, 1'b1);
    repeat (3) @(negedge clk);
    chk(tx_cnt == 1, "R4 odd tail dropped", tx_cnt, 1);
    dib[0] = 2'd0; dib[1] = 2'd3;
    e1 = {dib[1], dib[0]};
    tx_drive(2, 1'b1);
    repeat (3) @(negedge clk);
    chk(tx_cnt == 2, "R4 next frame count", tx_cnt, 2);
    chk(tx_got[0] == e0, "R4 first nibble", tx_got[0], e0);
    chk(tx_got[1] == e1, "R4 realigned nibble", tx_got[1], e1);
  endtask

  task automatic t_rx_frame(input int n, input bit fast, input int seed, input string req);
    int rep, exp_len, idx;
    logic [1:0] e;
    clear_mon();
    speed = fast;
    rep = fast ? 1 : 10;
    for (int i = 0; i < n; i++) src[i] = 4'((i * 7 + seed) % 16);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_dv = 1'b1; rx_nib = src[i];
      #1;
      while (!rx_take) begin @(negedge clk); #1; end
    end
    @(negedge clk); rx_dv = 1'b0; rx_nib = 4'hx;
    repeat (2 * rep + 4) @(negedge clk);
    exp_len = n * 2 * rep;
    chk(take_cnt == n, {req, " takes"}, take_cnt, n);
    chk(rx_cnt == exp_len, {req, " crs_dv length R8"}, rx_cnt, exp_len);
    chk(rx_last - rx_first + 1 == rx_cnt, {req, " gapless R7"}, rx_last - rx_first + 1, rx_cnt);
    chk(rx_bad == 0, "R8 rxd zero while idle", rx_bad, 0);
    chk(crs_dv == 1'b0, "R8 crs_dv low after frame", crs_dv, 0);
    for (int j = 0; j < exp_len && j < 256; j++) begin
      idx = j / rep;
      e = (idx % 2 == 0) ? src[idx/2][1:0] : src[idx/2][3:2];
      if (rx_got[j] != e) begin
        chk(1'b0, {req, " dibit data"}, rx_got[j], e);
        break;
      end
    end
    chk(1'b1, {req, " dibit scan"}, 0, 0);
  endtask

  task automatic t_rx_idle();
    clear_mon();
    speed = 1'b1;
    rx_dv = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rx_nib = 4'(i);
    end
    repeat (2) @(negedge clk);
    chk(take_cnt == 0, "R10 no take while dv low", take_cnt, 0);
    chk(rx_cnt == 0, "R10 no crs_dv while dv low", rx_cnt, 0);
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_tx_idle();
    t_tx_frame(1'b1, 0, "R2");
    t_tx_frame(1'b1, 2, "R2");
    t_tx_frame(1'b0, 1, "R5");
    t_tx_odd();
    t_rx_frame(6, 1'b1, 3, "R6");
    t_rx_frame(1, 1'b1, 9, "R6");
    t_rx_frame(3, 1'b0, 5, "R9");
    t_rx_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule